// File: doc/BRIEF.md
# Serial ADC Polling Master

This block is the host side of a link to an 8-bit, eight-channel serial ADC that runs from the host's serial clock. It drives the converter's chip select, serial clock and data input. It also samples the converter's data output. While `run` is high it polls without a pause: every frame carries one control byte that requests a conversion. The result of that conversion comes back while the next control byte is already going out, so frames overlap and the serial clock never stops inside a session.

Two frame cadences are available. The short one has 10 serial clocks per conversion, which is the shortest the converter allows. The long one has 16 clocks, for hosts that must move data in whole bytes. The cadence is chosen by `mode16`, and the channel for each request comes from `chan_sel`. Both are taken once per frame. Each finished result leaves the block as a one-cycle `result_valid` pulse, together with the 3-bit channel that was asked for. The serial clock runs at the system clock divided by `2*SCLK_HALF`.

Top module: `adcpoll_master`

## Requirements
- R1: Out of reset, and whenever no session is running, `adc_cs_n` is 1 while `adc_sclk`, `adc_din` and `result_valid` are 0.
- R2: Each frame opens with an 8-bit control byte. It is sent MSB first, changes on the serial clock falling edge, and is valid at the rising edge. Its bits are a 1 (the start bit), then `chan_sel[2:0]` MSB first, then the four bits of parameter `CTRL_TAIL` MSB first. The last of these is the power-down bit. `adc_din` is 0 for the rest of the frame.
- R3: With `mode16`=0 a frame is exactly 10 serial clocks long, so start bits are 10 rising edges apart. With `mode16`=1 a frame is 16 clocks long. No idle clocks are placed between frames.
- R4: The result requested by a frame is sampled at 8 consecutive rising edges, MSB first. The first is the last clock of that frame, and the other seven are the first seven clocks of the following frame. `result_data` carries those bits.
- R5: `result_chan` equals the channel field of the control byte that requested the result.
- R6: The data window at the start of a session, or after an abort, is discarded. A session produces exactly one result per control byte sent.
- R7: `adc_cs_n` stays low for a whole session. When `run` is low at a frame's last falling edge, the block does not send a new byte. It clocks a 7-clock frame with `adc_din` at 0 to finish the last result, then raises `adc_cs_n`.
- R8: `mode16` is taken only at frame starts, so changing it mid-frame does not alter the length of the running frame.
- R9: A high `abort` drives `adc_cs_n` to 1 and `adc_sclk` to 0 on the next clock. No result pending at that point is ever reported.
- R10: Every serial clock high phase and low phase lasts `SCLK_HALF` system clocks.
- R11: `result_valid` is high for exactly one system clock per result.
- R12: `chan_sel` is taken only at frame starts. Changes during a frame do not alter the byte being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep polling while high |
| abort | input | 1 | Immediate session end, pending results dropped |
| mode16 | input | 1 | 1: 16 clocks per frame, 0: 10 clocks per frame |
| chan_sel | input | 3 | Channel for the next control byte |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Serial control data to the converter |
| adc_dout | input | 1 | Serial result data from the converter |
| result_valid | output | 1 | One-cycle strobe for a finished result |
| result_data | output | 8 | Result bits, MSB first as received |
| result_chan | output | 3 | Channel tag of the result |

## Verification
The bench plays a converter that returns random data and records every serial edge. It then rebuilds the expected control bytes, frame lengths and results from the channel and mode values present when each frame was latched. `chan_sel` and `mode16` are toggled at random in mid-frame, so a design that samples them late would send a wrong byte or cut a frame short. Single-frame sessions and stops at random points test the flush frame. A design that reported the empty first window, or that dropped the last result, would return the wrong number of results. Aborts early in a session, and after several results, test that a late strobe cannot leak out and that the first window after a restart is discarded again.

// File: rtl/adcpoll_pkg.sv
package adcpoll_pkg;
  localparam int RES_W     = 8;
  localparam int CH_W      = 3;
  localparam int TAIL_W    = 4;
  localparam int FAST_LEN  = 10;
  localparam int ALIGN_LEN = 16;
  localparam int FLUSH_LEN = RES_W - 1;
  localparam int CYC_W     = $clog2(ALIGN_LEN + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adcpoll_sclk_gen.sv
module adcpoll_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q, sclk_d;
  logic at_end;

  generate
    if (HALF == 1) begin : g_nodiv
      assign at_end = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt_q, cnt_d;

      assign at_end = (cnt_q == CW'(HALF - 1));

      always_comb begin
        if (clr || !en || at_end) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assert_half_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(HALF - 1));
    end
  endgenerate

  assign rise = en & ~clr & at_end & ~sclk_q;
  assign fall = en & ~clr & at_end & sclk_q;

  always_comb begin
    if (clr || !en) sclk_d = 1'b0;
    else if (at_end) sclk_d = ~sclk_q;
    else             sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_d;
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/adcpoll_frame_ctl.sv
module adcpoll_frame_ctl
  import adcpoll_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            abort,
  input  logic            mode16,
  input  logic [CH_W-1:0] chan,
  input  logic            rise,
  input  logic            fall,
  output logic            active,
  output logic            cs_n,
  output logic            tx_load,
  output logic            tx_clr,
  output logic            tx_shift,
  output logic            emit,
  output logic [CH_W-1:0] emit_ch
);
  seq_state_e       st_q, st_d;
  logic             cs_n_q, cs_n_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             len16_q, len16_d;
  logic [CH_W-1:0]  tag_cur_q, tag_cur_d;
  logic [CH_W-1:0]  tag_prev_q, tag_prev_d;
  logic             prev_q, prev_d;
  logic [CYC_W-1:0] last_cyc;
  logic             boundary;

  always_comb begin
    if (st_q == ST_FLUSH) last_cyc = CYC_W'(FLUSH_LEN - 1);
    else if (len16_q)     last_cyc = CYC_W'(ALIGN_LEN - 1);
    else                  last_cyc = CYC_W'(FAST_LEN - 1);
  end

  assign boundary = fall && (cyc_q == last_cyc);

  always_comb begin
    st_d       = st_q;
    cs_n_d     = cs_n_q;
    cyc_d      = cyc_q;
    len16_d    = len16_q;
    tag_cur_d  = tag_cur_q;
    tag_prev_d = tag_prev_q;
    prev_d     = prev_q;
    tx_load    = 1'b0;
    tx_clr     = 1'b0;
    tx_shift   = 1'b0;
    if (abort) begin
      st_d   = ST_IDLE;
      cs_n_d = 1'b1;
      cyc_d  = '0;
      prev_d = 1'b0;
      tx_clr = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (run) begin
            st_d      = ST_RUN;
            cs_n_d    = 1'b0;
            cyc_d     = '0;
            len16_d   = mode16;
            tag_cur_d = chan;
            prev_d    = 1'b0;
            tx_load   = 1'b1;
          end
        end
        ST_RUN: begin
          if (boundary) begin
            cyc_d      = '0;
            prev_d     = 1'b1;
            tag_prev_d = tag_cur_q;
            if (run) begin
              len16_d   = mode16;
              tag_cur_d = chan;
              tx_load   = 1'b1;
            end else begin
              st_d   = ST_FLUSH;
              tx_clr = 1'b1;
            end
          end else if (fall) begin
            cyc_d    = cyc_q + 1'b1;
            tx_shift = 1'b1;
          end
        end
        ST_FLUSH: begin
          if (boundary) begin
            st_d   = ST_IDLE;
            cs_n_d = 1'b1;
            cyc_d  = '0;
            prev_d = 1'b0;
          end else if (fall) begin
            cyc_d    = cyc_q + 1'b1;
            tx_shift = 1'b1;
          end
        end
        default: begin
          st_d   = ST_IDLE;
          cs_n_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cs_n_q     <= 1'b1;
      cyc_q      <= '0;
      len16_q    <= 1'b0;
      tag_cur_q  <= '0;
      tag_prev_q <= '0;
      prev_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      cs_n_q     <= cs_n_d;
      cyc_q      <= cyc_d;
      len16_q    <= len16_d;
      tag_cur_q  <= tag_cur_d;
      tag_prev_q <= tag_prev_d;
      prev_q     <= prev_d;
    end
  end

  assign active  = (st_q != ST_IDLE);
  assign cs_n    = cs_n_q;
  assign emit    = rise & prev_q & ~abort & (cyc_q == CYC_W'(RES_W - 2));
  assign emit_ch = tag_prev_q;

  assert_mode_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !boundary && !abort) |=> $stable(len16_q));

  assert_cyc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (cyc_q <= last_cyc));
endmodule

// File: rtl/adcpoll_tx_path.sv
module adcpoll_tx_path
  import adcpoll_pkg::*;
#(
  parameter logic [TAIL_W-1:0] TAIL = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            clr,
  input  logic            shift,
  input  logic [CH_W-1:0] chan,
  output logic            din
);
  localparam int BYTE_W = 1 + CH_W + TAIL_W;

  logic [BYTE_W-1:0] sh_q, sh_d;

  always_comb begin
    if (clr)        sh_d = '0;
    else if (load)  sh_d = {1'b1, chan, TAIL};
    else if (shift) sh_d = {sh_q[BYTE_W-2:0], 1'b0};
    else            sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign din = sh_q[BYTE_W-1];
endmodule

// File: rtl/adcpoll_rx_path.sv
module adcpoll_rx_path
  import adcpoll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             dout,
  input  logic             emit,
  input  logic [CH_W-1:0]  emit_ch,
  output logic             valid,
  output logic [RES_W-1:0] data,
  output logic [CH_W-1:0]  chan
);
  logic [RES_W-2:0] sh_q, sh_d;
  logic             v_q, v_d;
  logic [RES_W-1:0] data_q, data_d;
  logic [CH_W-1:0]  chan_q, chan_d;

  always_comb begin
    sh_d   = rise ? {sh_q[RES_W-3:0], dout} : sh_q;
    v_d    = emit;
    data_d = emit ? {sh_q, dout} : data_q;
    chan_d = emit ? emit_ch : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      v_q    <= 1'b0;
      data_q <= '0;
      chan_q <= '0;
    end else begin
      sh_q   <= sh_d;
      v_q    <= v_d;
      data_q <= data_d;
      chan_q <= chan_d;
    end
  end

  assign valid = v_q;
  assign data  = data_q;
  assign chan  = chan_q;

  assert_valid_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |=> !v_q);
endmodule

// File: rtl/adcpoll_master.sv
module adcpoll_master
  import adcpoll_pkg::*;
#(
  parameter int                SCLK_HALF = 2,
  parameter logic [TAIL_W-1:0] CTRL_TAIL = 4'b1111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             abort,
  input  logic             mode16,
  input  logic [CH_W-1:0]  chan_sel,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_din,
  input  logic             adc_dout,
  output logic             result_valid,
  output logic [RES_W-1:0] result_data,
  output logic [CH_W-1:0]  result_chan
);
  logic [1:0]      rst_pipe_q;
  logic            rst_sn;
  logic            active, rise, fall;
  logic            tx_load, tx_clr, tx_shift;
  logic            emit;
  logic [CH_W-1:0] emit_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  adcpoll_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
    .clk(clk), .rst_n(rst_sn), .en(active), .clr(abort),
    .sclk(adc_sclk), .rise(rise), .fall(fall)
  );

  adcpoll_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_sn), .run(run), .abort(abort), .mode16(mode16),
    .chan(chan_sel), .rise(rise), .fall(fall), .active(active),
    .cs_n(adc_cs_n), .tx_load(tx_load), .tx_clr(tx_clr),
    .tx_shift(tx_shift), .emit(emit), .emit_ch(emit_ch)
  );

  adcpoll_tx_path #(.TAIL(CTRL_TAIL)) u_tx (
    .clk(clk), .rst_n(rst_sn), .load(tx_load), .clr(tx_clr),
    .shift(tx_shift), .chan(chan_sel), .din(adc_din)
  );

  adcpoll_rx_path u_rx (
    .clk(clk), .rst_n(rst_sn), .rise(rise), .dout(adc_dout),
    .emit(emit), .emit_ch(emit_ch), .valid(result_valid),
    .data(result_data), .chan(result_chan)
  );

  assert_abort_stop_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    abort |=> (adc_cs_n && !adc_sclk));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    adc_cs_n |-> (!adc_sclk && !adc_din));
endmodule

// File: tb/tb_adcpoll_master.sv
module tb_adcpoll_master;
  localparam int         HALF = 2;
  localparam logic [3:0] TAIL = 4'b1011;

  logic       clk, rst_n, run, abort, mode16, adc_dout;
  logic [2:0] chan_sel;
  logic       adc_cs_n, adc_sclk, adc_din, result_valid;
  logic [7:0] result_data;
  logic [2:0] result_chan;

  adcpoll_master #(.SCLK_HALF(HALF), .CTRL_TAIL(TAIL)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .abort(abort), .mode16(mode16),
    .chan_sel(chan_sel), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_din(adc_din), .adc_dout(adc_dout), .result_valid(result_valid),
    .result_data(result_data), .result_chan(result_chan)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit rec = 0, rand_on = 0, mode_rand = 0;
  int nr = 0, nf = 0, nv = 0, cs_rises = 0, sclk_bad = 0, sclk_ok = 0, pulse_bad = 0;
  logic din_r [0:1023];
  logic dout_r[0:1023];
  logic mode_f[0:1023];
  logic [2:0] chan_f[0:1023];
  logic [7:0] vd[0:63];
  logic [2:0] vc[0:63];
  logic prev_v = 0, prev_cs = 1, last_s = 0;
  int   ph_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge adc_sclk) if (rec && nr < 1024) begin
    din_r[nr] = adc_din; dout_r[nr] = adc_dout; nr++;
  end
  always @(negedge adc_sclk) if (rec && nf < 1024) begin
    mode_f[nf] = mode16; chan_f[nf] = chan_sel; nf++;
  end

  always @(negedge clk) if (rst_n) begin
    if (result_valid) begin
      if (prev_v) pulse_bad++;
      if (nv < 64) begin vd[nv] = result_data; vc[nv] = result_chan; end
      nv++;
    end
    prev_v = result_valid;
    if (adc_cs_n && !prev_cs) cs_rises++;
    prev_cs = adc_cs_n;
    if (!adc_cs_n) begin
      if (adc_sclk == last_s) ph_cnt++;
      else begin
        if (ph_cnt == HALF) sclk_ok++; else sclk_bad++;
        ph_cnt = 1; last_s = adc_sclk;
      end
    end else begin
      ph_cnt = 0; last_s = 1'b0;
    end
  end

  task automatic clear_rec();
    nr = 0; nf = 0; nv = 0; cs_rises = 0; sclk_bad = 0; sclk_ok = 0; pulse_bad = 0;
  endtask

  task automatic analyze(input logic [2:0] ch0, input logic m0);
    int q = 0, k = 0, last_p = 0, last_l = 0;
    bit gap = 0;
    while (q < nr) begin
      if (din_r[q]) begin
        int         len;
        logic [2:0] ech;
        logic [7:0] cb, ex, eb;
        bit         zok;
        len = (((q == 0) ? m0 : mode_f[q-1]) == 1'b1) ? 16 : 10;
        ech = (q == 0) ? ch0 : chan_f[q-1];
        eb  = {1'b1, ech, TAIL};
        cb  = '0;
        for (int i = 0; i < 8; i++) cb = {cb[6:0], (q + i < nr) ? din_r[q+i] : 1'b0};
        chk(cb == eb, "R2 R12 control byte", int'(cb), int'(eb));
        zok = 1;
        for (int i = 8; i < len; i++) if (q + i < nr && din_r[q+i]) zok = 0;
        chk(zok && !gap, "R3 R8 frame spacing", int'(zok && !gap), 1);
        if (q + len + 6 < nr) begin
          ex = '0;
          for (int i = 0; i < 8; i++) ex = {ex[6:0], dout_r[q+len-1+i]};
          chk(k < nv && k < 64 && vd[k] == ex, "R4 result data", int'(vd[k]), int'(ex));
          chk(k < nv && k < 64 && vc[k] == ech, "R5 result channel", int'(vc[k]), int'(ech));
        end
        k++; last_p = q; last_l = len; q += len; gap = 0;
      end else begin
        gap = 1; q++;
      end
    end
    chk(nv == k, "R6 one result per control byte", nv, k);
    chk(nr == last_p + last_l + 7, "R7 flush frame length", nr, last_p + last_l + 7);
    chk(cs_rises == 1, "R7 chip select held low in session", cs_rises, 1);
    chk(sclk_bad == 0 && sclk_ok > 0, "R10 serial clock phases", sclk_bad, 0);
    chk(pulse_bad == 0, "R11 single-cycle strobe", pulse_bad, 0);
  endtask

  task automatic session(input logic m, input int nres, input bit mr);
    logic [2:0] c0;
    logic       m0;
    clear_rec();
    mode16 = m; chan_sel = 3'($urandom);
    c0 = chan_sel; m0 = mode16;
    rec = 1; rand_on = 1; mode_rand = mr;
    @(negedge clk); run = 1'b1;
    while (nv < nres - 1 || nr < 1) @(negedge clk);
    repeat ($urandom % 20) @(negedge clk);
    run = 1'b0;
    while (!adc_cs_n) @(negedge clk);
    rand_on = 0; mode_rand = 0;
    repeat (4) @(negedge clk);
    rec = 0;
    analyze(c0, m0);
  endtask

  task automatic do_abort(input int min_res, input int min_rises);
    int held;
    clear_rec();
    mode16 = 1'b0; chan_sel = 3'($urandom);
    rec = 1; rand_on = 1;
    @(negedge clk); run = 1'b1;
    while (nv < min_res || nr < min_rises) @(negedge clk);
    repeat ($urandom % 3) @(negedge clk);
    abort = 1'b1; run = 1'b0;
    @(negedge clk);
    abort = 1'b0;
    chk(adc_cs_n == 1'b1, "R9 chip select after abort", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, "R9 serial clock after abort", int'(adc_sclk), 0);
    held = nv;
    repeat (80) @(negedge clk);
    chk(nv == held, "R9 no result after abort", nv, held);
    rand_on = 0; rec = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; run = 0; abort = 0; mode16 = 0; chan_sel = 0; adc_dout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 reset chip select", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, "R1 reset serial clock", int'(adc_sclk), 0);
    chk(adc_din == 1'b0, "R1 reset data in", int'(adc_din), 0);
    chk(result_valid == 1'b0, "R1 reset strobe", int'(result_valid), 0);

    fork
      forever begin
        @(posedge adc_sclk); #1;
        if (rand_on) chan_sel = 3'($urandom);
        if (mode_rand && ($urandom % 3 == 0)) mode16 = ~mode16;
      end
      forever begin
        @(negedge adc_sclk);
        adc_dout = 1'($urandom);
      end
    join_none

    session(1'b0, 6, 1'b0);
    session(1'b1, 5, 1'b0);
    session(1'b0, 1, 1'b0);
    session(1'b1, 1, 1'b0);
    session(1'b0, 12, 1'b1);
    session(1'b1, 10, 1'b1);
    do_abort(0, 12);
    chk(nv == 0, "R6 R9 no result before second window", nv, 0);
    session(1'b1, 4, 1'b0);
    do_abort(3, 0);
    session(1'b0, 5, 1'b1);
    chk(adc_cs_n && !adc_sclk && !adc_din, "R1 idle after sessions",
        int'({adc_cs_n, adc_sclk, adc_din}), 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule